// File: doc/BRIEF.md
# Serial DAC Code Register

This block is the digital front end of a voltage-output converter. A host sends a 16-bit word over a three-wire serial link: an active-low select, a serial clock and a data line. Bits enter a shift register most significant first, one on each rising edge of the serial clock while the select is low. When the select goes high again, the word moves into a holding register whose upper bits drive the converter code. The block runs on a system clock at least four times faster than the serial clock. It resynchronises all three link signals and works from edges it detects in the system clock domain.

The resolution is a parameter of 12, 14 or 16 bits. The code is always taken from the top of the 16-bit word, and the trailing bits are discarded. A second parameter selects what reset and the active-low clear load: zero-scale (code 0) or midscale (only the top code bit set). The clear acts on the holding register without waiting for a clock edge. Any frame that is in progress while the clear is low is thrown away. A frame with fewer than 16 serial clock edges leaves the code unchanged and raises a sticky framing-error flag. A frame with more than 16 edges keeps only the last 16 bits that were shifted in.

Top module: `serdac_front`

## Requirements
- R1: While the synchronous reset is low at a clock edge, the code becomes the reset value and the error flag becomes 0. The reset value is 0 with MID_RESET=0, and 2^(RES_BITS-1) with MID_RESET=1 (8192 at 14 bits).
- R2: While the select is low, each rising serial clock edge shifts one data bit in, most significant first. On the select's rising edge, a frame of exactly 16 edges sets the code to bits [15:16-RES_BITS] of the word received. The first bit sent is bit 15.
- R3: While the select is high, serial clock edges and data changes do not change the code, and they do not affect the next frame.
- R4: In a frame of more than 16 edges, the last 16 bits shifted in form the word that is loaded.
- R5: A frame with fewer than 16 edges leaves the code unchanged and sets the error flag.
- R6: The error flag stays set through further short frames. The next complete frame clears it.
- R7: At 12 or 14 bits, the 4 or 2 trailing bits of the word have no effect on the code.
- R8: A low level on the clear input sets the code to the reset value at once, without a clock edge, and holds it there while the input stays low. The clear leaves the error flag unchanged.
- R9: If the clear is low at any time while the select is low, that frame is not loaded when the select rises, and the error flag is not changed.
- R10: The bit count restarts at each falling edge of the select, so the edges of an earlier short frame do not count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear of the code to the reset value |
| link_sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| link_csn | input | 1 | Active-low frame select; its rising edge loads the word |
| link_sdata | input | 1 | Serial data, most significant bit first |
| code_o | output | RES_BITS | Code driving the converter |
| frame_err_o | output | 1 | Sticky flag: the last finished frame was short |

## Verification
A bit counter that is off by one, or a shift register that is not cleared, shows up on code_o at the first select rise after the fault. It appears either as a code shifted by one bit position, or as a complete frame wrongly flagged on frame_err_o. A stuck abort marker shows up as a frame that is never loaded, seen three to four system clocks after the select rises. A clear path that is not asynchronous shows up as a stale code sampled between clock edges while the clear is low. Random frames of short, exact and overlong length are mixed with directed clear and idle-clock cases, and they are compared against a model of the last 16 bits and the flag.

// File: rtl/serdac_pkg.sv
// Package: constants and helpers shared by the serial DAC front end.
// Assumes the serial word is always 16 bits, whatever the resolution.
package serdac_pkg;
    localparam int unsigned FRAME_BITS = 16;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

    // Value loaded into the code register on reset or on clear.
    function automatic logic [FRAME_BITS-1:0] reset_code(input int unsigned res_bits,
                                                         input bit mid);
        logic [FRAME_BITS-1:0] v;
        v = '0;
        if (mid) v[res_bits-1] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/serdac_sync.sv
// Module: multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes that each bit is sampled on its own; bits are not coherent with each other.
module serdac_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= INIT;
        else        stg[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-samples the stage before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= INIT;
            else        stg[s] <= stg[s-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/serdac_shifter.sv
// Module: serial shift register with a saturating bit counter and a frame abort marker.
// Assumes its inputs are already synchronised and edge-detected. A select fall and
// a serial clock rise are expected not to be detected in the same cycle.
module serdac_shifter
    import serdac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_on,
    input  logic                  frame_start,
    input  logic                  bit_strobe,
    input  logic                  bit_val,
    input  logic                  clr_s_n,
    output logic [FRAME_BITS-1:0] word_o,
    output logic [CNT_W-1:0]      bit_cnt_o,
    output logic                  frame_full_o,
    output logic                  abort_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);

    assign frame_full_o = (bit_cnt_o == CNT_MAX);

    // Shifts data in MSB first and counts edges, saturating at a full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o    <= '0;
            bit_cnt_o <= '0;
        end else if (frame_start) begin
            bit_cnt_o <= '0;
        end else if (frame_on && bit_strobe) begin
            word_o <= {word_o[FRAME_BITS-2:0], bit_val};
            if (!frame_full_o) bit_cnt_o <= bit_cnt_o + 1'b1;
        end
    end

    // Marks a frame as discarded if the clear is seen while the frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n)                     abort_o <= 1'b0;
        else if (frame_start)           abort_o <= !clr_s_n;
        else if (frame_on && !clr_s_n)  abort_o <= 1'b1;
    end
endmodule

// File: rtl/serdac_latch.sv
// Module: code holding register with asynchronous clear, plus the sticky frame error flag.
// Assumes that load_en and frame_done are single-cycle pulses in the clk domain.
module serdac_latch
    import serdac_pkg::*;
#(
    parameter int unsigned RES_BITS  = 14,
    parameter bit          MID_RESET = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_n,
    input  logic                  load_en,
    input  logic                  frame_done,
    input  logic                  frame_full,
    input  logic [FRAME_BITS-1:0] word_i,
    output logic [RES_BITS-1:0]   code_o,
    output logic                  frame_err_o
);
    localparam logic [FRAME_BITS-1:0] RST_WORD = reset_code(RES_BITS, MID_RESET);
    localparam logic [RES_BITS-1:0]   RST_CODE = RST_WORD[RES_BITS-1:0];

    logic [RES_BITS-1:0] code_next;
    assign code_next = word_i[FRAME_BITS-1 -: RES_BITS];

    if (RES_BITS < FRAME_BITS) begin : g_trail
        logic unused_trail;
        assign unused_trail = ^word_i[FRAME_BITS-RES_BITS-1:0];
    end

    // Holds the code; clear acts at once, reset and load act at the clock edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)       code_o <= RST_CODE;
        else if (!rst_n)  code_o <= RST_CODE;
        else if (load_en) code_o <= code_next;
    end

    // Sets the error flag on a finished short frame; clears it on a complete one.
    always_ff @(posedge clk) begin
        if (!rst_n)          frame_err_o <= 1'b0;
        else if (frame_done) frame_err_o <= !frame_full;
    end
endmodule

// File: rtl/serdac_front.sv
// Module: top of the serial DAC front end. It synchronises the link, detects edges,
// shifts in the word and loads the code on the select's rising edge.
// Assumes clk runs at least four times the serial clock rate.
module serdac_front
    import serdac_pkg::*;
#(
    parameter int unsigned RES_BITS    = 14,
    parameter bit          MID_RESET   = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_n,
    input  logic                link_sclk,
    input  logic                link_csn,
    input  logic                link_sdata,
    output logic [RES_BITS-1:0] code_o,
    output logic                frame_err_o
);
    // Bit order on the synchroniser bus: {clear, data, select, serial clock}.
    logic [3:0] sync_bus;
    logic       sclk_s, csn_s, sdata_s, clr_s_n;
    logic       sclk_q, csn_q;
    logic       sclk_rise, cs_fall, cs_rise;
    logic [FRAME_BITS-1:0] word;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  frame_full;
    logic                  frame_abort;
    logic                  frame_done;
    logic                  load_en;

    serdac_sync #(
        .WIDTH (4),
        .STAGES(SYNC_STAGES),
        .INIT  (4'b1010)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({clr_n, link_sdata, link_csn, link_sclk}),
        .sync_o (sync_bus)
    );

    assign sclk_s  = sync_bus[0];
    assign csn_s   = sync_bus[1];
    assign sdata_s = sync_bus[2];
    assign clr_s_n = sync_bus[3];

    // Keeps the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    assign sclk_rise  = sclk_s & ~sclk_q;
    assign cs_fall    = ~csn_s & csn_q;
    assign cs_rise    = csn_s & ~csn_q;
    assign frame_done = cs_rise & ~frame_abort;
    assign load_en    = frame_done & frame_full;

    serdac_shifter shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_on    (~csn_s),
        .frame_start (cs_fall),
        .bit_strobe  (sclk_rise),
        .bit_val     (sdata_s),
        .clr_s_n     (clr_s_n),
        .word_o      (word),
        .bit_cnt_o   (bit_cnt),
        .frame_full_o(frame_full),
        .abort_o     (frame_abort)
    );

    serdac_latch #(
        .RES_BITS (RES_BITS),
        .MID_RESET(MID_RESET)
    ) latch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_n      (clr_n),
        .load_en    (load_en),
        .frame_done (frame_done),
        .frame_full (frame_full),
        .word_i     (word),
        .code_o     (code_o),
        .frame_err_o(frame_err_o)
    );
endmodule

// File: rtl/serdac_front_chk.sv
// Module: property checker for serdac_front, attached by bind below.
module serdac_front_chk
    import serdac_pkg::*;
#(
    parameter int unsigned RES_BITS  = 14,
    parameter bit          MID_RESET = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr_n,
    input logic [RES_BITS-1:0] code_o,
    input logic                frame_err_o,
    input logic                cs_rise,
    input logic                load_en,
    input logic                frame_full,
    input logic                frame_abort,
    input logic [CNT_W-1:0]    bit_cnt
);
    localparam logic [FRAME_BITS-1:0] RW = reset_code(RES_BITS, MID_RESET);
    localparam logic [RES_BITS-1:0]   RC = RW[RES_BITS-1:0];

    AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> code_o == RC); // R8
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && $past(clr_n) && !$past(load_en)) |-> $stable(code_o)); // R3
    AST_SHORT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !frame_full && !frame_abort) |=> frame_err_o); // R5
    AST_SHORT_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !frame_full && clr_n) |=> (!clr_n || $stable(code_o))); // R5
    AST_FULL_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !frame_err_o); // R6
    AST_ABORT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && frame_abort && clr_n) |=> (!clr_n || $stable(code_o))); // R9
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS)); // R4
endmodule

bind serdac_front serdac_front_chk #(
    .RES_BITS (RES_BITS),
    .MID_RESET(MID_RESET)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .code_o     (code_o),
    .frame_err_o(frame_err_o),
    .cs_rise    (cs_rise),
    .load_en    (load_en),
    .frame_full (frame_full),
    .frame_abort(frame_abort),
    .bit_cnt    (bit_cnt)
);

// File: tb/serdac_front_tb.sv
// Bench: directed corners plus seeded random frames, checked against a bench model.
module serdac_front_tb_top;
    localparam int unsigned RES = 14;
    localparam bit          MID = 1'b1;
    localparam logic [RES-1:0] RSTV = MID ? RES'(1 << (RES - 1)) : '0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic sclk = 1'b0;
    logic csn = 1'b1;
    logic sdata = 1'b0;
    logic [RES-1:0] code;
    logic err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [RES-1:0] exp_code;
    logic exp_err;

    serdac_front #(.RES_BITS(RES), .MID_RESET(MID)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .link_sclk(sclk), .link_csn(csn), .link_sdata(sdata),
        .code_o(code), .frame_err_o(err)
    );

    always #10 clk = ~clk;

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    function automatic logic [RES-1:0] code_of(input logic [15:0] w);
        return w[15 -: RES];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends n bits of val, highest first, with the select low the whole time.
    task automatic frame(input logic [31:0] val, input int n);
        csn = 1'b0;
        waitc(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = val[i];
            waitc(4);
            sclk = 1'b1;
            waitc(4);
            sclk = 1'b0;
        end
        waitc(4);
        csn = 1'b1;
        waitc(8);
    endtask

    // Updates the bench model for a frame of n bits that was not aborted.
    task automatic model(input logic [31:0] val, input int n);
        if (n >= 16) begin
            exp_code = code_of(val[15:0]);
            exp_err  = 1'b0;
        end else begin
            exp_err = 1'b1;
        end
    endtask

    task automatic frame_chk(input logic [31:0] val, input int n, input string req);
        frame(val, n);
        model(val, n);
        check(req, code, exp_code);
        check(req, err, exp_err);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        waitc(5);
        rst_n = 1'b1;
        waitc(2);
        exp_code = RSTV;
        exp_err  = 1'b0;
        check("R1", code, RSTV);
        check("R1", err, 1'b0);

        frame_chk(32'h0000_A5C3, 16, "R2");
        frame_chk(32'h0000_FFFF, 16, "R2");
        // R7: same top bits, different trailing bits, same code.
        frame_chk(32'h0000_1234, 16, "R7");
        frame_chk(32'h0000_1237, 16, "R7");
        // R4: 19 bits; only the low 16 are kept.
        frame_chk(32'h0007_8001, 19, "R4");
        // R5 and R6: short frames keep the code and set a sticky flag.
        frame_chk(32'h0000_00FF, 9, "R5");
        frame_chk(32'h0000_0003, 3, "R6");
        // R10: the count restarts, so this full frame is accepted.
        frame_chk(32'h0000_4321, 16, "R10");

        // R3: serial clock toggling with the select high changes nothing.
        for (int i = 0; i < 6; i++) begin
            sdata = i[0];
            waitc(3); sclk = 1'b1; waitc(3); sclk = 1'b0;
        end
        waitc(6);
        check("R3", code, exp_code);
        frame_chk(32'h0000_9AB8, 16, "R3");

        // R8: asynchronous clear, checked between clock edges.
        @(posedge clk);
        #5 clr_n = 1'b0;
        #2 check("R8", code, RSTV);
        waitc(4);
        check("R8", code, RSTV);
        check("R8", err, exp_err);
        clr_n = 1'b1;
        exp_code = RSTV;
        waitc(4);
        check("R8", code, RSTV);

        // R9: a clear during an open frame discards that frame.
        csn = 1'b0;
        waitc(4);
        for (int i = 15; i >= 0; i--) begin
            sdata = 1'b1;
            if (i == 8) begin clr_n = 1'b0; waitc(4); clr_n = 1'b1; end
            waitc(4); sclk = 1'b1; waitc(4); sclk = 1'b0;
        end
        waitc(4);
        csn = 1'b1;
        waitc(8);
        check("R9", code, RSTV);
        check("R9", err, exp_err);

        // Random frames of short, exact and overlong length.
        for (int k = 0; k < 40; k++) begin
            int n;
            logic [31:0] v;
            n = 4 + int'($urandom % 17);
            v = $urandom;
            if (n < 16) frame_chk(v, n, "R5");
            else if (n == 16) frame_chk(v, n, "R2");
            else frame_chk(v, n, "R4");
        end

        // R1: reset returns the code and the flag to their start values.
        frame_chk(32'h0000_0005, 5, "R6");
        rst_n = 1'b0;
        waitc(3);
        rst_n = 1'b1;
        waitc(2);
        check("R1", code, RSTV);
        check("R1", err, 1'b0);
        report();
    end
endmodule